// File: doc/BRIEF.md
# Buffered 8N1 UART Transceiver

This block sends and receives serial bytes in a fixed frame. Each frame has one low start bit, eight data bits with the least significant bit first, no parity bit, and one high stop bit. The serial line idles high. The clock frequency and the baud rate are parameters. From them the core works out how many clock cycles one bit lasts, and how many cycles make half a bit. The receiver uses the half-bit count to place its samples near the middle of each bit.

Logic on the parallel side only handles bytes. Bytes offered on the transmit ready/valid port are queued in a small transmit FIFO. A transmit state machine takes them from the FIFO one at a time and shifts them onto the line. The receiver works as follows:

1. It watches for a falling edge on the line.
2. After half a bit it checks that the line is still low.
3. It samples the eight data bits and then checks the stop bit.
4. It places each good byte in a small receive FIFO, which drains through the receive ready/valid port.

A busy flag for each direction shows when that direction is in the middle of a frame.

Top module: `uart_core`

## Requirements
- R1: After reset the serial output is high, tx_ready_o is 1, rx_valid_o is 0, and both busy flags are 0.
- R2: A transmitted frame holds a low start bit for one bit time. It then sends the 8 data bits, least significant bit first, one bit time each. It ends with a high stop bit for one bit time. When no frame is being sent, the line stays high.
- R3: One bit time is CLK_HZ/BAUD clock cycles (10 with the default parameters). Half a bit is that value divided by two, and never less than 1.
- R4: tx_ready_o is 1 exactly when the transmit FIFO (FIFO_DEPTH bytes, default 8) has a free slot. Start from idle and write DEPTH+1 bytes back to back: every one is accepted, because the first moves at once into the shifter. After that, tx_ready_o is 0.
- R5: tx_busy_o goes high in the cycle after a byte is taken from the transmit FIFO. It stays high until the stop bit of the last queued byte has completed. The line is driven low only while tx_busy_o is high.
- R6: The receiver builds a byte from the bits sampled in the middle of each bit time, least significant bit first. Bytes come out on rx_data_o in the order they arrived. rx_data_o stays stable while rx_valid_o is 1 and rx_ready_i is 0.
- R7: If the line is low for less than half a bit, that is a glitch. No byte is produced, and the receiver returns to idle.
- R8: A frame whose stop bit samples low is a framing error, and its byte is dropped. The receiver waits for the line to go high before it looks for the next start bit.
- R9: A good byte that arrives while the receive FIFO is full is discarded. The bytes already held in the FIFO are kept.
- R10: rx_busy_o is high from the cycle after the start edge is detected until the receiver is back in idle. It is low during a glitch-free idle line.
- R11: With the serial output looped back to the serial input, the bytes 0x55, 0xA3, 0x00 and 0xFF come back unchanged and in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tx_data_i | input | 8 | Byte to send |
| tx_valid_i | input | 1 | tx_data_i is offered |
| tx_ready_o | output | 1 | Transmit FIFO has a free slot |
| rx_data_o | output | 8 | Oldest received byte |
| rx_valid_o | output | 1 | Receive FIFO holds a byte |
| rx_ready_i | input | 1 | Consumer takes rx_data_o |
| line_tx_o | output | 1 | Serial output, idle high |
| line_rx_i | input | 1 | Serial input, idle high |
| tx_busy_o | output | 1 | Transmitter inside a frame |
| rx_busy_o | output | 1 | Receiver inside a frame |

## Verification
The loopback test uses four bytes:

- 0x55 and 0xA3 have alternating and irregular bit patterns, so a swapped bit order or an off-by-one shift shows up.
- 0x00 and 0xFF make the data bits look like the start bit or the stop bit, so they expose a wrong sampling point.

A single frame of 0xA3 is checked bit by bit at the middle of each bit time. This catches a bit-time length or bit order that a loopback test would hide, because both directions would share the same error. Frames are also driven onto the input by hand:

- a short low pulse tells a glitch apart from a real start bit;
- a frame with a low stop bit tells a framing error apart from a good frame;
- a burst of DEPTH+1 bytes fills both FIFOs, which separates the rule for dropping a new byte from the rule for keeping the oldest.

// File: rtl/uart_pkg.sv
package uart_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_DATA, ST_STOP} frame_st_e;

  function automatic int half_bit(input int cpb);
    return (cpb > 1) ? cpb / 2 : 1;
  endfunction
endpackage

// File: rtl/uart_byte_fifo.sv
module uart_byte_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         rd_en_i,
  output logic [W-1:0] rd_data_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] count_q;
  logic          do_wr, do_rd;

  assign full_o    = (count_q == CW'(DEPTH));
  assign empty_o   = (count_q == '0);
  assign do_wr     = wr_en_i && !full_o;   // writes while full are dropped
  assign do_rd     = rd_en_i && !empty_o;
  assign rd_data_o = mem_q[rd_ptr_q];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_wr) mem_q[wr_ptr_q] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (do_wr) wr_ptr_q <= nxt(wr_ptr_q);
      if (do_rd) rd_ptr_q <= nxt(rd_ptr_q);
      case ({do_wr, do_rd})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: ;
      endcase
    end
  end

  // R4
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CW'(DEPTH));

  // R6
  head_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!empty_o && !rd_en_i) |=> $stable(rd_data_o));
endmodule

// File: rtl/uart_tx_fsm.sv
module uart_tx_fsm
  import uart_pkg::*;
#(
  parameter int CPB = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       fifo_empty_i,
  input  logic [7:0] fifo_data_i,
  output logic       pop_o,
  output logic       line_o,
  output logic       busy_o
);
  localparam int CNTW = (CPB > 1) ? $clog2(CPB) : 1;
  localparam logic [CNTW-1:0] CNT_LOAD = CNTW'(CPB - 1);

  frame_st_e       st_q;
  logic [CNTW-1:0] cnt_q;
  logic [2:0]      idx_q;
  logic [7:0]      sh_q;
  logic            launch;

  // start a new frame from idle or straight after a finished stop bit
  assign launch = !fifo_empty_i &&
                  (st_q == ST_IDLE || (st_q == ST_STOP && cnt_q == '0));
  assign pop_o  = launch;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
      line_o <= 1'b1;
      busy_o <= 1'b0;
    end else if (launch) begin
      sh_q   <= fifo_data_i;
      cnt_q  <= CNT_LOAD;
      idx_q  <= '0;
      busy_o <= 1'b1;
      st_q   <= ST_START;
      line_o <= 1'b0;
    end else begin
      case (st_q)
        ST_START:
          if (cnt_q == '0) begin
            st_q   <= ST_DATA;
            cnt_q  <= CNT_LOAD;
            line_o <= sh_q[0];
          end else cnt_q <= cnt_q - 1'b1;
        ST_DATA:
          if (cnt_q == '0) begin
            cnt_q <= CNT_LOAD;
            if (idx_q == 3'd7) begin
              st_q   <= ST_STOP;
              line_o <= 1'b1;
            end else begin
              idx_q  <= idx_q + 1'b1;
              sh_q   <= sh_q >> 1;
              line_o <= sh_q[1];
            end
          end else cnt_q <= cnt_q - 1'b1;
        ST_STOP:
          if (cnt_q == '0) begin
            st_q   <= ST_IDLE;
            busy_o <= 1'b0;
          end else cnt_q <= cnt_q - 1'b1;
        default: ;
      endcase
    end
  end

  // R5
  tx_low_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !line_o |-> busy_o);

  // R2
  tx_idle_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE) |-> line_o);
endmodule

// File: rtl/uart_rx_fsm.sv
module uart_rx_fsm
  import uart_pkg::*;
#(
  parameter int CPB  = 10,
  parameter int HALF = 5
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       line_i,
  output logic       push_o,
  output logic [7:0] byte_o,
  output logic       busy_o
);
  localparam int CNTW = (CPB > 1) ? $clog2(CPB) : 1;
  localparam logic [CNTW-1:0] CNT_LOAD = CNTW'(CPB - 1);
  localparam logic [CNTW-1:0] HALF_LOAD = CNTW'(HALF - 1);

  frame_st_e       st_q;
  logic [CNTW-1:0] cnt_q;
  logic [2:0]      idx_q;
  logic [7:0]      sh_q;
  logic [1:0]      sync_q;
  logic            err_q;
  logic            rx_s;

  assign rx_s   = sync_q[1];
  assign byte_o = sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b11;
    else         sync_q <= {sync_q[0], line_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
      err_q  <= 1'b0;
      push_o <= 1'b0;
      busy_o <= 1'b0;
    end else begin
      push_o <= 1'b0;
      case (st_q)
        ST_IDLE:
          if (!rx_s) begin
            st_q   <= ST_START;
            cnt_q  <= HALF_LOAD;
            busy_o <= 1'b1;
          end
        ST_START:
          if (cnt_q == '0) begin
            if (!rx_s) begin
              st_q  <= ST_DATA;
              cnt_q <= CNT_LOAD;
              idx_q <= '0;
            end else begin   // glitch
              st_q   <= ST_IDLE;
              busy_o <= 1'b0;
            end
          end else cnt_q <= cnt_q - 1'b1;
        ST_DATA:
          if (cnt_q == '0) begin
            sh_q  <= {rx_s, sh_q[7:1]};
            cnt_q <= CNT_LOAD;
            if (idx_q == 3'd7) st_q <= ST_STOP;
            else               idx_q <= idx_q + 1'b1;
          end else cnt_q <= cnt_q - 1'b1;
        ST_STOP:
          if (cnt_q == '0) begin
            if (rx_s) begin
              push_o <= !err_q;
              err_q  <= 1'b0;
              st_q   <= ST_IDLE;
              busy_o <= 1'b0;
            end else err_q <= 1'b1;   // framing error: hold until line high
          end else cnt_q <= cnt_q - 1'b1;
        default: ;
      endcase
    end
  end

  // R10
  rx_active_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_IDLE) |-> busy_o);

  // R10
  rx_push_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |-> (!busy_o && $past(busy_o)));
endmodule

// File: rtl/uart_core.sv
module uart_core
  import uart_pkg::*;
#(
  parameter int CLK_HZ     = 10_000_000,
  parameter int BAUD       = 1_000_000,
  parameter int FIFO_DEPTH = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] tx_data_i,
  input  logic       tx_valid_i,
  output logic       tx_ready_o,
  output logic [7:0] rx_data_o,
  output logic       rx_valid_o,
  input  logic       rx_ready_i,
  output logic       line_tx_o,
  input  logic       line_rx_i,
  output logic       tx_busy_o,
  output logic       rx_busy_o
);
  localparam int CPB_RAW = CLK_HZ / BAUD;
  localparam int CPB     = (CPB_RAW < 1) ? 1 : CPB_RAW;
  localparam int HALF    = half_bit(CPB);

  logic       txf_full, txf_empty, tx_pop;
  logic [7:0] txf_data;
  logic       rxf_full, rxf_empty, rx_push;
  logic [7:0] rx_byte;

  uart_byte_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_tx_fifo (
    .clk_i, .rst_ni,
    .wr_en_i(tx_valid_i), .wr_data_i(tx_data_i),
    .rd_en_i(tx_pop), .rd_data_o(txf_data),
    .full_o(txf_full), .empty_o(txf_empty)
  );

  uart_tx_fsm #(.CPB(CPB)) u_tx (
    .clk_i, .rst_ni,
    .fifo_empty_i(txf_empty), .fifo_data_i(txf_data), .pop_o(tx_pop),
    .line_o(line_tx_o), .busy_o(tx_busy_o)
  );

  uart_rx_fsm #(.CPB(CPB), .HALF(HALF)) u_rx (
    .clk_i, .rst_ni,
    .line_i(line_rx_i), .push_o(rx_push), .byte_o(rx_byte), .busy_o(rx_busy_o)
  );

  uart_byte_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_rx_fifo (
    .clk_i, .rst_ni,
    .wr_en_i(rx_push), .wr_data_i(rx_byte),
    .rd_en_i(rx_ready_i), .rd_data_o(rx_data_o),
    .full_o(rxf_full), .empty_o(rxf_empty)
  );

  assign tx_ready_o = !txf_full;
  assign rx_valid_o = !rxf_empty;

  // R6
  rx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_o && !rx_ready_i) |=> (rx_valid_o && $stable(rx_data_o)));

  // R9
  rx_full_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rxf_full |-> rx_valid_o);
endmodule

// File: tb/uart_core_tb.sv
module uart_core_tb;
  localparam int CPB   = 10;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] tx_data = '0;
  logic tx_valid = 1'b0, rx_ready = 1'b0;
  logic tx_ready, rx_valid, line_tx, tx_busy, rx_busy;
  logic [7:0] rx_data;
  logic loop_en = 1'b1, bench_rx = 1'b1;
  logic line_rx;
  int total = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz
  assign line_rx = loop_en ? line_tx : bench_rx;

  uart_core #(.CLK_HZ(10_000_000), .BAUD(1_000_000), .FIFO_DEPTH(DEPTH)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .tx_data_i(tx_data), .tx_valid_i(tx_valid), .tx_ready_o(tx_ready),
    .rx_data_o(rx_data), .rx_valid_o(rx_valid), .rx_ready_i(rx_ready),
    .line_tx_o(line_tx), .line_rx_i(line_rx),
    .tx_busy_o(tx_busy), .rx_busy_o(rx_busy)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    for (int i = 0; i < 2000 && !tx_ready; i++) @(negedge clk);
    tx_data  = b;
    tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic pop_byte(output logic [7:0] b, output bit got);
    @(negedge clk);
    for (int i = 0; i < 3000 && !rx_valid; i++) @(negedge clk);
    got = rx_valid;
    b = rx_data;
    if (got) begin
      rx_ready = 1'b1;
      @(negedge clk);
      rx_ready = 1'b0;
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive_frame(input logic [7:0] b, input logic stop_bit);
    @(negedge clk);
    bench_rx = 1'b0;
    wait_cyc(CPB);
    for (int k = 0; k < 8; k++) begin
      bench_rx = b[k];
      wait_cyc(CPB);
      // R10 receiver busy in mid-frame
      if (k == 3) check(rx_busy == 1'b1, "R10 rx_busy mid-frame", rx_busy, 1);
    end
    bench_rx = stop_bit;
    wait_cyc(CPB);
    bench_rx = 1'b1;
  endtask

  task automatic t_reset;
    check(line_tx == 1'b1, "R1 line idle", line_tx, 1);
    check(tx_ready == 1'b1, "R1 tx_ready", tx_ready, 1);
    check(rx_valid == 1'b0, "R1 rx_valid", rx_valid, 0);
    check(tx_busy == 1'b0 && rx_busy == 1'b0, "R1 busy flags", {tx_busy, rx_busy}, 0);
  endtask

  task automatic t_frame_shape;
    logic [7:0] b = 8'hA3;
    int seen = 0;
    loop_en = 1'b0;
    send_byte(b);
    for (int i = 0; i < 50 && line_tx; i++) @(negedge clk);
    check(line_tx == 1'b0, "R2 start edge", line_tx, 0);
    wait_cyc(CPB / 2);
    check(line_tx == 1'b0, "R2 start bit mid", line_tx, 0);
    for (int k = 0; k < 8; k++) begin
      wait_cyc(CPB);
      if (line_tx != b[k]) seen++;
      if (k == 4) check(tx_busy == 1'b1, "R5 tx_busy in frame", tx_busy, 1);
    end
    check(seen == 0, "R2 R3 data bits LSB first", seen, 0);
    wait_cyc(CPB);
    check(line_tx == 1'b1, "R2 stop bit", line_tx, 1);
    wait_cyc(CPB);
    check(tx_busy == 1'b0 && line_tx == 1'b1, "R5 idle after stop", {tx_busy, line_tx}, 1);
    loop_en = 1'b1;
  endtask

  task automatic t_loopback;
    logic [7:0] exp_q [4] = '{8'h55, 8'hA3, 8'h00, 8'hFF};
    logic [7:0] b;
    bit got;
    for (int i = 0; i < 4; i++) send_byte(exp_q[i]);
    wait_cyc(4 * 10 * CPB + 50);
    for (int i = 0; i < 4; i++) begin
      pop_byte(b, got);
      check(got && b == exp_q[i], "R11 R6 loopback byte", b, exp_q[i]);
    end
    check(rx_valid == 1'b0, "R6 rx empty after drain", rx_valid, 0);
  endtask

  task automatic t_fill;
    logic [7:0] b;
    bit got;
    for (int i = 0; i <= DEPTH; i++) begin
      @(negedge clk);
      check(tx_ready == 1'b1, "R4 slot free in burst", tx_ready, 1);
      tx_data  = 8'h10 + 8'(i);
      tx_valid = 1'b1;
    end
    @(negedge clk);
    tx_valid = 1'b0;
    check(tx_ready == 1'b0, "R4 tx fifo full", tx_ready, 0);
    wait_cyc((DEPTH + 1) * 10 * CPB + 60);
    check(tx_busy == 1'b0, "R5 tx_busy after last stop", tx_busy, 0);
    for (int i = 0; i < DEPTH; i++) begin
      pop_byte(b, got);
      check(got && b == 8'h10 + 8'(i), "R9 kept bytes", b, 8'h10 + i);
    end
    @(negedge clk);
    check(rx_valid == 1'b0, "R9 extra byte discarded", rx_valid, 0);
  endtask

  task automatic t_glitch;
    loop_en = 1'b0;
    @(negedge clk);
    bench_rx = 1'b0;
    wait_cyc(3);
    bench_rx = 1'b1;
    wait_cyc(4 * CPB);
    check(rx_valid == 1'b0, "R7 glitch no byte", rx_valid, 0);
    check(rx_busy == 1'b0, "R7 R10 idle after glitch", rx_busy, 0);
  endtask

  task automatic t_framing;
    logic [7:0] b;
    bit got;
    drive_frame(8'h3C, 1'b0);
    wait_cyc(3 * CPB);
    check(rx_valid == 1'b0, "R8 framing error dropped", rx_valid, 0);
    check(rx_busy == 1'b0, "R8 idle after line high", rx_busy, 0);
    drive_frame(8'h96, 1'b1);
    wait_cyc(2 * CPB);
    check(rx_valid == 1'b1, "R6 good frame after error", rx_valid, 1);
    pop_byte(b, got);
    check(got && b == 8'h96, "R6 R8 byte value", b, 8'h96);
    loop_en = 1'b1;
  endtask

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(2);
    t_reset();
    t_frame_shape();
    t_loopback();
    t_fill();
    t_glitch();
    t_framing();
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule